// File: doc/BRIEF.md
# Serial Configuration Bitstream Streamer

The block keeps a configuration image in an on-chip register array and sends it out one bit per serial clock to a programmable-logic target. For test, the image is loaded through a parallel word write port. The target samples the serial data line on each rising edge of the serial clock. The block moves to the next image bit one system clock after that edge, so the data line stays stable across the sampling edge.

A mode input sets where the serial clock comes from:

- **Master:** the block makes the serial clock by dividing the system clock and drives it onto the pin.
- **Slave:** the block takes the serial clock from the previous device in a chain. It passes the clock through a two-stage synchronizer and detects edges against the system clock.

An active-high enable input has two jobs. It allows counting, and when low it holds the bit counter at zero. An active-low select input gates the data pin and the counting. A done flag shows that the whole image has been sent.

Top module: `cfg_bit_streamer`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` as image word `wr_addr`. Image bit k is bit k%WORD_W of word k/WORD_W, and bit k is the k-th bit sent (index 0 first).
- R2: While `oe` is high, `cs_n` is low and `done` is low, `data_oe` is 1 and `data_out` carries image bit `count`. Bit 0 is present as soon as `oe` is high and `cs_n` is low, before any serial clock rising edge.
- R3: Each serial clock rising edge seen while enabled advances the count by exactly one. The advance happens after the edge (one system clock later in master mode, three in slave mode), so `data_out` is stable across the edge.
- R4: While `oe` is low, the count is reset to zero on each system clock, `done` is cleared, `data_oe` is 0 and `dclk_out` is 0.
- R5: While `cs_n` is high, `data_oe` is 0, the count holds, serial clock edges are ignored and the master clock rests low. When `cs_n` returns low, streaming resumes at the held bit.
- R6: In master mode (`master`=1), `dclk_oe` is 1 and `dclk_out` rises once every 2*HALF_DIV system clocks while streaming.
- R7: In slave mode (`master`=0), `dclk_oe` is 0 and `dclk_out` is 0.
- R8: `done` asserts when the count reaches IMG_BITS and stays high until `oe` goes low. Further serial clock edges are ignored, and in master mode `dclk_out` stays low.
- R9: After `done`, if DONE_HIGH=1 the data pin is driven to 1 (`data_oe`=1, `data_out`=1); if DONE_HIGH=0 the data pin is released (`data_oe`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Image word write strobe |
| wr_addr | input | WA | Image word index |
| wr_data | input | WORD_W | Image word value |
| master | input | 1 | 1: generate serial clock, 0: accept it from `dclk_in` |
| oe | input | 1 | High: enable counting and data; low: reset count |
| cs_n | input | 1 | Active-low select |
| dclk_in | input | 1 | Serial clock from the previous device (slave mode) |
| dclk_out | output | 1 | Generated serial clock value |
| dclk_oe | output | 1 | Drive enable for the serial clock pin |
| data_out | output | 1 | Serial data value |
| data_oe | output | 1 | Drive enable for the serial data pin |
| done | output | 1 | Whole image sent |

## Verification
The bench acts as the target. It samples the data line at every observed serial clock rising edge, in both modes, and checks the full 64-bit image against a pattern computed arithmetically.

It targets the following corner cases, each with the failure it would expose:
- **Timing of the advance.** A counter that advanced on the same system clock as the rising edge would show the next bit at the sampling point.
- **Deselect mid-stream.** A design that let deselect reset the count, or counted through it, would resume at the wrong bit.
- **Enable drop mid-stream.** A design that failed to restart at bit 0 after a drop of the enable would be caught.
- **End of image.** A design whose done flag released, whose clock kept toggling, or whose data pin took the wrong level for the chosen setting after the last bit would be caught.

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer #(
  parameter int IMG_BITS = 64,
  parameter int WORD_W = 8,
  parameter int HALF_DIV = 3,
  parameter bit DONE_HIGH = 1'b0,
  localparam int NWORDS = IMG_BITS / WORD_W,
  localparam int WA = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WA-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              master,
  input  logic              oe,
  input  logic              cs_n,
  input  logic              dclk_in,
  output logic              dclk_out,
  output logic              dclk_oe,
  output logic              data_out,
  output logic              data_oe,
  output logic              done
);
  localparam int CW = $clog2(IMG_BITS + 1);
  localparam int BW = (IMG_BITS > 1) ? $clog2(IMG_BITS) : 1;
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [IMG_BITS-1:0] img;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dv;
  logic dclk_q, s1, s2, prev;

  wire src  = master ? dclk_q : s2;
  wire rise = src & ~prev;
  assign done = (cnt == CW'(IMG_BITS));
  wire run  = oe & ~cs_n & ~done;

  always_ff @(posedge clk) begin
    if (wr_en)
      for (int w = 0; w < NWORDS; w++)
        if (wr_addr == WA'(w)) img[w*WORD_W +: WORD_W] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!oe)        cnt <= '0;
    else if (run && rise) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv <= '0;
      dclk_q <= 1'b0;
    end else if (!(run && master)) begin
      dv <= '0;
      dclk_q <= 1'b0;
    end else if (dv == DW'(HALF_DIV - 1)) begin
      dv <= '0;
      dclk_q <= ~dclk_q;
    end else begin
      dv <= dv + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1 <= dclk_in;
      s2 <= s1;
      prev <= src;
    end
  end

  assign dclk_oe  = master;
  assign dclk_out = master & dclk_q;
  assign data_oe  = oe & ~cs_n & (~done | DONE_HIGH);
  assign data_out = done ? 1'b1 : img[cnt[BW-1:0]];

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oe) && $past(rst_n)) |-> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1)));

  p_oe_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> (cnt == '0 && !done));

  p_csn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && oe) |=> $stable(cnt));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && oe) |=> done);

  p_dclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master && (done || !oe)) |=> !dclk_out);
endmodule

// File: tb/sim_cfg_bit_streamer.sv
module sim_cfg_bit_streamer;
  localparam int IMG_BITS = 64;
  localparam int WORD_W = 8;
  localparam int HALF_DIV = 3;
  localparam int NWORDS = IMG_BITS / WORD_W;
  localparam int WA = $clog2(NWORDS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [WA-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic master = 1'b1, oe = 1'b0, cs_n = 1'b1, dclk_in = 1'b0;
  logic dclk_out, dclk_oe, data_out, data_oe, done;
  logic d1_out, d1_oe, k1_out, k1_oe, done1;

  int nchk = 0, nerr = 0, k = 0;

  always #5 clk = ~clk;

  cfg_bit_streamer #(.IMG_BITS(IMG_BITS), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .DONE_HIGH(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .master(master), .oe(oe), .cs_n(cs_n), .dclk_in(dclk_in),
    .dclk_out(dclk_out), .dclk_oe(dclk_oe), .data_out(data_out), .data_oe(data_oe), .done(done));

  cfg_bit_streamer #(.IMG_BITS(IMG_BITS), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV), .DONE_HIGH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .master(master), .oe(oe), .cs_n(cs_n), .dclk_in(dclk_in),
    .dclk_out(k1_out), .dclk_oe(k1_oe), .data_out(d1_out), .data_oe(d1_oe), .done(done1));

  function automatic logic [WORD_W-1:0] word_of(int w);
    return WORD_W'((w * 29 + 7) ^ 8'h5A);
  endfunction

  function automatic logic bit_of(int b);
    logic [WORD_W-1:0] wv = word_of(b / WORD_W);
    return wv[b % WORD_W];
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic master_recv(input int upto);
    logic pv = dclk_out;
    int gap = 0;
    bit seen = 0;
    int guard = 0;
    while (k < upto && guard < 5000) begin
      @(negedge clk);
      guard++;
      gap++;
      if (dclk_out && !pv) begin
        chk(data_oe && data_out == bit_of(k), "R1 R2 R3 master bit", int'(data_out), int'(bit_of(k)));
        if (seen) chk(gap == 2 * HALF_DIV, "R6 dclk period", gap, 2 * HALF_DIV);
        seen = 1;
        gap = 0;
        k++;
      end
      pv = dclk_out;
    end
    chk(k == upto, "R3 master edge count", k, upto);
  endtask

  task automatic slave_pulse();
    dclk_in = 1'b1;
    repeat (4) @(negedge clk);
    dclk_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1500000;
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk(!data_oe && !dclk_out && !done, "R4 reset state", int'({data_oe, dclk_out, done}), 0);
    rst_n = 1'b1;

    for (int w = 0; w < NWORDS; w++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = WA'(w);
      wr_data = word_of(w);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // master full stream, DONE_HIGH=1 on u0, 0 on u1
    master = 1'b1;
    cs_n = 1'b0;
    oe = 1'b1;
    #1;
    chk(data_oe && data_out == bit_of(0), "R2 first bit before clock", int'(data_out), int'(bit_of(0)));
    chk(dclk_oe == 1'b1, "R6 master drives clock", int'(dclk_oe), 1);
    k = 0;
    master_recv(IMG_BITS);
    repeat (3) @(negedge clk);
    chk(done && done1, "R8 done after last bit", int'(done), 1);
    chk(data_oe && data_out, "R9 data high after done", int'({data_oe, data_out}), 3);
    chk(!d1_oe, "R9 data released after done", int'(d1_oe), 0);
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (dclk_out || !done) bad++;
    end
    chk(bad == 0, "R8 clock idle and done held", bad, 0);

    oe = 1'b0;
    @(negedge clk);
    chk(!done && !data_oe && !dclk_out && !done1, "R4 oe low clears", int'({done, data_oe, dclk_out}), 0);

    // enable drop mid-stream restarts at bit 0
    oe = 1'b1;
    k = 0;
    master_recv(10);
    @(negedge clk);
    oe = 1'b0;
    @(negedge clk);
    chk(!dclk_out && !data_oe, "R4 clock low while oe low", int'({dclk_out, data_oe}), 0);
    oe = 1'b1;
    #1;
    chk(data_out == bit_of(0), "R4 restart at bit 0", int'(data_out), int'(bit_of(0)));

    // deselect mid-stream holds position
    k = 0;
    master_recv(21);
    @(negedge clk);
    cs_n = 1'b1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (data_oe || dclk_out) bad++;
    end
    chk(bad == 0, "R5 deselect releases pins", bad, 0);
    cs_n = 1'b0;
    #1;
    chk(data_oe && data_out == bit_of(21), "R5 resume at held bit", int'(data_out), int'(bit_of(21)));
    master_recv(IMG_BITS);
    repeat (3) @(negedge clk);
    chk(done, "R8 done after resumed stream", int'(done), 1);

    // slave mode
    oe = 1'b0;
    master = 1'b0;
    @(negedge clk);
    oe = 1'b1;
    @(negedge clk);
    chk(!dclk_oe && !dclk_out, "R7 slave releases clock", int'({dclk_oe, dclk_out}), 0);
    bad = 0;
    for (int b = 0; b < IMG_BITS; b++) begin
      if (b == 30) begin
        cs_n = 1'b1;
        slave_pulse();
        slave_pulse();
        cs_n = 1'b0;
        #1;
        chk(data_out == bit_of(30), "R5 slave edges ignored when deselected", int'(data_out), int'(bit_of(30)));
      end
      if (!(data_oe && data_out == bit_of(b))) begin
        bad++;
        $display("FAIL R3 slave bit %0d actual=%0d expected=%0d", b, data_out, bit_of(b));
      end
      nchk++;
      if (dclk_out || dclk_oe) bad++;
      slave_pulse();
    end
    nerr += bad;
    chk(done, "R8 slave done", int'(done), 1);
    slave_pulse();
    slave_pulse();
    chk(done && data_oe && data_out && !d1_oe, "R8 R9 slave after done", int'({done, data_oe, data_out, d1_oe}), 14);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule